// File: doc/BRIEF.md
# Trap Entry and Vectoring Unit

This block handles exception entry for a small 16-bit CPU core. It accepts three kinds of request. The first is a software trap carrying a 7-bit trap number. The second is a set of eight hardware trap conditions. The third is an ordinary interrupt request with its priority level and vector number. When the core is free, the block picks one request and computes the handler's vector address. It then saves the machine state on the system stack, one 16-bit word per cycle. Last, it hands the core a new instruction pointer, code segment, stack pointer and status word.

Traps cannot be masked and always beat interrupts. Hardware conditions are latched until they are serviced, so a condition that arrives while an entry is in progress is not lost. A software trap keeps the caller's priority level and never acknowledges the interrupt controller. Only an accepted interrupt raises the level and pulses the acknowledge. A per-input mode bit tells the pipeline whether the faulting instruction must be cancelled.

Top module: `trap_entry_unit`

## Requirements
- R1: Out of idle, a pending hardware trap wins over a software trap, and a software trap wins over an interrupt, whatever the interrupt's level. A request that loses the choice is not serviced.
- R2: When several hardware conditions are pending, the lowest input index is taken first. The others stay latched and are serviced in ascending index order on later entries.
- R3: The vector address is the trap number shifted left by two, giving 16-bit values from 0x0000 to 0x01FC. A software trap uses its operand. An interrupt uses `irq_num_i`. Hardware input i uses entry i of the number table, which by default is 0x20+i.
- R4: Words are pushed one per cycle, starting the cycle after acceptance, each at the stack pointer pre-decremented by 2. The status word goes first (at sp-2), then the zero-extended code segment if segmentation is on, then the instruction pointer. `ip_load_o` is high in the cycle after the last push, and `new_sp_o` then equals sp minus twice the word count.
- R5: With segmentation on, `new_csp_o` is 0. With it off, the segment is not pushed and `new_csp_o` equals the sampled segment.
- R6: A software or hardware trap returns the sampled status word unchanged, including the level field in bits 15:12. A software trap never asserts `irq_ack_o`.
- R7: An interrupt is accepted only when `irq_lvl_i` is greater than `psw_i[15:12]`. When accepted, `new_psw_o` carries the interrupt level in bits 15:12, and `irq_ack_o` is high for exactly the first push cycle. When rejected, nothing happens.
- R8: `hw_cancel_o` is high during the first push cycle of a hardware-trap entry whose cancel mode bit is set. By default, inputs 0 to 3 cancel and 4 to 7 complete. It is low otherwise.
- R9: A hardware condition that pulses during an entry is serviced by the next entry, which is accepted after one idle cycle.
- R10: `busy_o` is high from the cycle after acceptance through the load cycle. Software-trap and interrupt requests presented while busy are ignored.
- R11: During and right after reset, `busy_o`, `push_we_o`, `ip_load_o`, `irq_ack_o` and `hw_cancel_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_trap_req_i | input | 1 | Software trap request |
| sw_trap_num_i | input | 7 | Software trap number |
| hw_trap_i | input | 8 | Hardware trap condition pulses, bit 0 highest priority |
| irq_req_i | input | 1 | Interrupt request |
| irq_lvl_i | input | 4 | Interrupt priority level |
| irq_num_i | input | 7 | Interrupt vector number |
| psw_i | input | 16 | Current status word, level in bits 15:12 |
| csp_i | input | 8 | Current code segment |
| ip_i | input | 16 | Instruction pointer to save |
| sp_i | input | 16 | Current stack pointer |
| seg_en_i | input | 1 | Segmentation enabled |
| busy_o | output | 1 | Entry sequence in progress |
| push_we_o | output | 1 | Stack write strobe |
| push_addr_o | output | 16 | Stack write address |
| push_data_o | output | 16 | Stack write data |
| ip_load_o | output | 1 | Load new IP, segment, SP and status word |
| new_ip_o | output | 16 | Handler vector address |
| new_csp_o | output | 8 | Handler code segment |
| new_sp_o | output | 16 | Stack pointer after the pushes |
| new_psw_o | output | 16 | Status word for the handler |
| irq_ack_o | output | 1 | Interrupt accepted pulse |
| hw_cancel_o | output | 1 | Cancel the faulting instruction |

## Verification
A request is accepted on the rising edge where the block is idle. The first push is therefore visible in the next cycle, later pushes follow one per cycle, and the load comes one cycle after the last push. The strobes `irq_ack_o` and `hw_cancel_o` belong to the first push cycle. A latched hardware condition waiting behind an entry starts two edges after the load cycle. The bench drives inputs at falling edges and records every output at falling edges in a cycle counter. It compares each captured word, and the cycle index of the load, against these counts rather than waiting for any handshake.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_PSW, ST_CSP, ST_IP, ST_LOAD} seq_st_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_HW, SRC_SW, SRC_IRQ} src_e;
endpackage

// File: rtl/trap_hw_arb.sv
module trap_hw_arb #(
  parameter int unsigned NUM_HW = 8,
  parameter int unsigned TN_W   = 7,
  parameter logic [NUM_HW-1:0][TN_W-1:0] HW_NUMS = '0,
  parameter logic [NUM_HW-1:0] CANCEL_MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_HW-1:0] hw_trap_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [TN_W-1:0]   num_o,
  output logic              cancel_o
);
  logic [NUM_HW-1:0] pend_q, cand, grant;

  assign cand  = pend_q | hw_trap_i;
  // isolate lowest set bit: fixed priority, input 0 first
  assign grant = cand & (~cand + {{(NUM_HW-1){1'b0}}, 1'b1});
  assign valid_o  = |cand;
  assign cancel_o = |(grant & CANCEL_MASK);

  always_comb begin
    num_o = '0;
    for (int i = 0; i < NUM_HW; i++)
      if (grant[i]) num_o = num_o | HW_NUMS[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= take_i ? (cand & ~grant) : cand;
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  // R9
  pend_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned CSP_W = 8,
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  src_e             src_i,
  input  logic [AW-1:0]    vec_i,
  input  logic             cancel_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [AW-1:0]    psw_i,
  input  logic [CSP_W-1:0] csp_i,
  input  logic [AW-1:0]    ip_i,
  input  logic [AW-1:0]    sp_i,
  input  logic             seg_en_i,
  output logic             busy_o,
  output logic             push_we_o,
  output logic [AW-1:0]    push_addr_o,
  output logic [AW-1:0]    push_data_o,
  output logic             ip_load_o,
  output logic [AW-1:0]    new_ip_o,
  output logic [CSP_W-1:0] new_csp_o,
  output logic [AW-1:0]    new_sp_o,
  output logic [AW-1:0]    new_psw_o,
  output logic             irq_ack_o,
  output logic             hw_cancel_o
);
  localparam logic [AW-1:0] WORD_B = AW'(2);

  seq_st_e          st_q;
  src_e             src_q;
  logic [AW-1:0]    vec_q, psw_q, ip_q, sp_q;
  logic [CSP_W-1:0] csp_q;
  logic [LVL_W-1:0] lvl_q;
  logic             seg_q, cancel_q;

  assign busy_o      = (st_q != ST_IDLE);
  assign push_we_o   = (st_q == ST_PSW) || (st_q == ST_CSP) || (st_q == ST_IP);
  assign push_addr_o = sp_q - WORD_B;
  assign ip_load_o   = (st_q == ST_LOAD);
  assign new_ip_o    = vec_q;
  assign new_csp_o   = seg_q ? '0 : csp_q;
  assign new_sp_o    = sp_q;
  assign new_psw_o   = (src_q == SRC_IRQ) ? {lvl_q, psw_q[AW-LVL_W-1:0]} : psw_q;
  assign irq_ack_o   = (st_q == ST_PSW) && (src_q == SRC_IRQ);
  assign hw_cancel_o = (st_q == ST_PSW) && (src_q == SRC_HW) && cancel_q;

  always_comb begin
    unique case (st_q)
      ST_PSW:  push_data_o = psw_q;
      ST_CSP:  push_data_o = AW'(csp_q);
      ST_IP:   push_data_o = ip_q;
      default: push_data_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      src_q    <= SRC_NONE;
      vec_q    <= '0;
      psw_q    <= '0;
      ip_q     <= '0;
      sp_q     <= '0;
      csp_q    <= '0;
      lvl_q    <= '0;
      seg_q    <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q     <= ST_PSW;
          src_q    <= src_i;
          vec_q    <= vec_i;
          psw_q    <= psw_i;
          ip_q     <= ip_i;
          sp_q     <= sp_i;
          csp_q    <= csp_i;
          lvl_q    <= lvl_i;
          seg_q    <= seg_en_i;
          cancel_q <= cancel_i;
        end
        ST_PSW:  st_q <= seg_q ? ST_CSP : ST_IP;
        ST_CSP:  st_q <= ST_IP;
        ST_IP:   st_q <= ST_LOAD;
        default: st_q <= ST_IDLE;
      endcase
      if (push_we_o) sp_q <= sp_q - WORD_B;
    end
  end

  // checker-only push counter
  logic [2:0] push_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                push_cnt_q <= '0;
    else if (!busy_o)           push_cnt_q <= '0;
    else if (push_we_o)         push_cnt_q <= push_cnt_q + 3'd1;
  end

  // R4
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_we_o |=> (push_we_o ? (push_addr_o == $past(push_addr_o) - WORD_B) : ip_load_o));
  // R4
  push_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ip_load_o |-> (push_cnt_q == (seg_q ? 3'd3 : 3'd2)));
  // R10
  load_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ip_load_o |=> !busy_o);
  // R7
  ack_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> !irq_ack_o);
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int unsigned NUM_HW = 8,
  parameter int unsigned TN_W   = 7,
  parameter int unsigned AW     = 16,
  parameter int unsigned CSP_W  = 8,
  parameter int unsigned LVL_W  = 4,
  parameter logic [NUM_HW-1:0][TN_W-1:0] HW_NUMS =
    {7'h27, 7'h26, 7'h25, 7'h24, 7'h23, 7'h22, 7'h21, 7'h20},
  parameter logic [NUM_HW-1:0] CANCEL_MASK = 8'b0000_1111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_trap_req_i,
  input  logic [TN_W-1:0]   sw_trap_num_i,
  input  logic [NUM_HW-1:0] hw_trap_i,
  input  logic              irq_req_i,
  input  logic [LVL_W-1:0]  irq_lvl_i,
  input  logic [TN_W-1:0]   irq_num_i,
  input  logic [AW-1:0]     psw_i,
  input  logic [CSP_W-1:0]  csp_i,
  input  logic [AW-1:0]     ip_i,
  input  logic [AW-1:0]     sp_i,
  input  logic              seg_en_i,
  output logic              busy_o,
  output logic              push_we_o,
  output logic [AW-1:0]     push_addr_o,
  output logic [AW-1:0]     push_data_o,
  output logic              ip_load_o,
  output logic [AW-1:0]     new_ip_o,
  output logic [CSP_W-1:0]  new_csp_o,
  output logic [AW-1:0]     new_sp_o,
  output logic [AW-1:0]     new_psw_o,
  output logic              irq_ack_o,
  output logic              hw_cancel_o
);
  localparam int unsigned VEC_PAD = AW - TN_W - 2;

  logic            hw_valid, hw_cancel, irq_ok, start, take;
  logic [TN_W-1:0] hw_num, sel_num;
  src_e            sel_src;
  logic [AW-1:0]   sel_vec;

  trap_hw_arb #(
    .NUM_HW(NUM_HW), .TN_W(TN_W), .HW_NUMS(HW_NUMS), .CANCEL_MASK(CANCEL_MASK)
  ) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_trap_i(hw_trap_i),
    .take_i   (take),
    .valid_o  (hw_valid),
    .num_o    (hw_num),
    .cancel_o (hw_cancel)
  );

  assign irq_ok = irq_req_i && (irq_lvl_i > psw_i[AW-1 -: LVL_W]);

  always_comb begin
    if (hw_valid) begin
      sel_src = SRC_HW;  sel_num = hw_num;
    end else if (sw_trap_req_i) begin
      sel_src = SRC_SW;  sel_num = sw_trap_num_i;
    end else if (irq_ok) begin
      sel_src = SRC_IRQ; sel_num = irq_num_i;
    end else begin
      sel_src = SRC_NONE; sel_num = '0;
    end
  end

  assign sel_vec = {{VEC_PAD{1'b0}}, sel_num, 2'b00};
  assign start   = !busy_o && (sel_src != SRC_NONE);
  assign take    = start && (sel_src == SRC_HW);

  trap_seq #(.AW(AW), .CSP_W(CSP_W), .LVL_W(LVL_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .src_i      (sel_src),
    .vec_i      (sel_vec),
    .cancel_i   (hw_cancel),
    .lvl_i      (irq_lvl_i),
    .psw_i      (psw_i),
    .csp_i      (csp_i),
    .ip_i       (ip_i),
    .sp_i       (sp_i),
    .seg_en_i   (seg_en_i),
    .busy_o     (busy_o),
    .push_we_o  (push_we_o),
    .push_addr_o(push_addr_o),
    .push_data_o(push_data_o),
    .ip_load_o  (ip_load_o),
    .new_ip_o   (new_ip_o),
    .new_csp_o  (new_csp_o),
    .new_sp_o   (new_sp_o),
    .new_psw_o  (new_psw_o),
    .irq_ack_o  (irq_ack_o),
    .hw_cancel_o(hw_cancel_o)
  );

  // R1
  trap_beats_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && (hw_valid || sw_trap_req_i)) |=> !irq_ack_o);
  // R10
  busy_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ip_load_o) |=> busy_o);
endmodule

// File: tb/sim_trap_entry_unit.sv
`timescale 1ns/1ps
module sim_trap_entry_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        sw_req = 1'b0;
  logic [6:0]  sw_num = '0;
  logic [7:0]  hw = '0;
  logic        irq_req = 1'b0;
  logic [3:0]  irq_lvl = '0;
  logic [6:0]  irq_num = '0;
  logic [15:0] psw_v = 16'h0000, ip_v = 16'h0000, sp_v = 16'h0000;
  logic [7:0]  csp_v = 8'h00;
  logic        seg = 1'b0;

  logic        busy, pwe, ipld, ack, canc;
  logic [15:0] paddr, pdata, nip, nsp, npsw;
  logic [7:0]  ncsp;

  trap_entry_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .sw_trap_req_i(sw_req), .sw_trap_num_i(sw_num), .hw_trap_i(hw),
    .irq_req_i(irq_req), .irq_lvl_i(irq_lvl), .irq_num_i(irq_num),
    .psw_i(psw_v), .csp_i(csp_v), .ip_i(ip_v), .sp_i(sp_v), .seg_en_i(seg),
    .busy_o(busy), .push_we_o(pwe), .push_addr_o(paddr), .push_data_o(pdata),
    .ip_load_o(ipld), .new_ip_o(nip), .new_csp_o(ncsp), .new_sp_o(nsp),
    .new_psw_o(npsw), .irq_ack_o(ack), .hw_cancel_o(canc)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  logic [15:0] cap_addr [4];
  logic [15:0] cap_data [4];
  int          cap_n, cap_cyc;
  logic [15:0] cap_ip, cap_sp, cap_psw;
  logic [7:0]  cap_csp;
  logic        cap_ack, cap_canc;

  task automatic issue(input bit s, input logic [6:0] sn, input logic [7:0] h,
                       input bit q, input logic [3:0] ql, input logic [6:0] qn);
    @(negedge clk);
    sw_req = s; sw_num = sn; hw = h; irq_req = q; irq_lvl = ql; irq_num = qn;
    @(posedge clk);
  endtask

  // samples at falling edges; c counts cycles after the accepting edge
  task automatic collect(input bit inj_sw, input logic [7:0] inj_hw);
    cap_n = 0; cap_cyc = 0; cap_ack = 0; cap_canc = 0;
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      if (pwe && cap_n < 4) begin
        cap_addr[cap_n] = paddr; cap_data[cap_n] = pdata; cap_n++;
      end
      if (ack)  cap_ack = 1'b1;
      if (canc) cap_canc = 1'b1;
      if (c == 1) begin sw_req = 0; hw = '0; irq_req = 0; end
      if (c == 2) begin sw_req = inj_sw; sw_num = 7'h11; hw = inj_hw; end
      if (c == 3) begin sw_req = 0; hw = '0; end
      if (ipld) begin
        cap_ip = nip; cap_sp = nsp; cap_psw = npsw; cap_csp = ncsp; cap_cyc = c;
        break;
      end
    end
  endtask

  task automatic expect_entry(input string r, input bit sg, input logic [15:0] vec,
                              input logic [15:0] psw_exp, input bit ack_exp, input bit canc_exp);
    int n;
    n = sg ? 3 : 2;
    chk(cap_n == n, {"R4 push count ", r}, cap_n, n);
    chk(cap_cyc == n + 1, {"R4 load cycle ", r}, cap_cyc, n + 1);
    chk(cap_addr[0] == 16'(sp_v - 16'd2) && cap_data[0] == psw_v, {"R4 psw push ", r}, cap_data[0], psw_v);
    if (sg) chk(cap_addr[1] == 16'(sp_v - 16'd4) && cap_data[1] == {8'h00, csp_v},
                {"R5 csp push ", r}, cap_data[1], {8'h00, csp_v});
    chk(cap_addr[n-1] == 16'(sp_v - 16'(2*n)) && cap_data[n-1] == ip_v, {"R4 ip push ", r}, cap_data[n-1], ip_v);
    chk(cap_ip == vec, {"R3 vector ", r}, cap_ip, vec);
    chk(cap_csp == (sg ? 8'h00 : csp_v), {"R5 new csp ", r}, cap_csp, sg ? 8'h00 : csp_v);
    chk(cap_sp == 16'(sp_v - 16'(2*n)), {"R4 new sp ", r}, cap_sp, 16'(sp_v - 16'(2*n)));
    chk(cap_psw == psw_exp, {"R6/R7 new psw ", r}, cap_psw, psw_exp);
    chk(cap_ack == ack_exp, {"R7 ack ", r}, cap_ack, ack_exp);
    chk(cap_canc == canc_exp, {"R8 cancel ", r}, cap_canc, canc_exp);
  endtask

  task automatic expect_quiet(input string r);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      sw_req = 0; hw = '0; irq_req = 0;
      chk(!busy && !ack && !pwe, {r, " no entry"}, {busy, ack, pwe}, 0);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 during reset
    chk(!busy && !pwe && !ipld && !ack && !canc, "R11 in reset", {busy, pwe, ipld, ack, canc}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !pwe && !ipld && !ack && !canc, "R11 after reset", {busy, pwe, ipld, ack, canc}, 0);

    // R3 R5 R6 software trap sweep; some with a competing interrupt (R1)
    for (int n = 0; n < 128; n++) begin
      seg   = n[0];
      psw_v = {n[3:0] & 4'h7, 5'h0, n[6:0]};
      csp_v = 8'(n * 3 + 1);
      ip_v  = 16'(16'h4000 + n * 6);
      sp_v  = 16'(16'hFC00 - n * 2);
      issue(1'b1, 7'(n), 8'h00, (n % 8 == 3), 4'hF, 7'h3C);
      collect(1'b0, 8'h00);
      expect_entry("sw", seg, 16'(n << 2), psw_v, 1'b0, 1'b0);
    end

    // R2 R3 R8 hardware trap patterns; drain in ascending order
    for (int p = 1; p < 256; p++) begin
      bit first;
      seg   = p[1];
      psw_v = 16'(16'h3000 | p);
      csp_v = 8'(p);
      ip_v  = 16'(16'h8000 + p);
      sp_v  = 16'hF000;
      issue((p % 16 == 5), 7'h12, 8'(p), (p % 16 == 5), 4'hF, 7'h33);
      first = 1'b1;
      for (int k = 0; k < 8; k++) begin
        if (p[k]) begin
          if (!first) begin @(posedge clk); @(posedge clk); end
          first = 1'b0;
          collect(1'b0, 8'h00);
          expect_entry("R1 hw", seg, 16'((7'h20 + k) << 2), psw_v, 1'b0, (k < 4));
        end
      end
      expect_quiet("R2 drained");
    end

    // R7 interrupt level sweep
    seg = 1'b0; sp_v = 16'hE000; ip_v = 16'h1234; csp_v = 8'h05;
    for (int l = 0; l < 16; l++) begin
      for (int m = 0; m < 16; m++) begin
        logic [6:0] q;
        q = 7'((l * 16 + m) & 127);
        psw_v = {4'(l), 12'hA5C};
        issue(1'b0, 7'h00, 8'h00, 1'b1, 4'(m), q);
        if (m > l) begin
          collect(1'b0, 8'h00);
          expect_entry("R7 irq", 1'b0, 16'(q << 2), {4'(m), 12'hA5C}, 1'b1, 1'b0);
        end else begin
          expect_quiet("R7 irq rejected");
        end
      end
    end

    // R9 R10 hw condition and sw request arriving mid-sequence
    seg = 1'b1; psw_v = 16'h2001; csp_v = 8'h7E; ip_v = 16'h0ABC; sp_v = 16'hD000;
    issue(1'b1, 7'h55, 8'h00, 1'b0, 4'h0, 7'h00);
    collect(1'b1, 8'h40);
    expect_entry("R9 first sw", 1'b1, 16'h0154, psw_v, 1'b0, 1'b0);
    @(posedge clk); @(posedge clk);
    collect(1'b0, 8'h00);
    expect_entry("R9 latched hw6", 1'b1, 16'(7'h26 << 2), psw_v, 1'b0, 1'b0);
    expect_quiet("R10 sw while busy ignored");

    summary();
    $finish;
  end
endmodule